// File: doc/BRIEF.md
# Round-Robin Virtual Channel Allocator

This block hands out virtual channels of the next-hop router's input buffers to packets that are starting out. Each input buffer whose head flit has just been routed raises a request that names the chosen output port. For every output port the allocator keeps a bit mask of the downstream VCs that are currently free. The number of VCs can differ from port to port and is set by a parameter array.

All requests in a cycle are resolved together. The requesters that target the same port are ordered round-robin, starting just after the requester that last won on that port. The first of them gets the lowest free VC, the next gets the next lowest free VC, and so on. A requester that finds nothing left is answered with an invalid indication. Answers are registered and appear one cycle after the request. A granted VC leaves the free mask. It comes back when the tail of its packet has gone and a release (port, VC) is pulsed.

Top module: `vc_rr_alloc`

## Requirements
- R1: While reset is high and on the cycle after it falls, every VC with index below its port's count is free (mask bit = 1) and no response is valid.
- R2: A request in cycle t produces gnt_valid for that requester in cycle t+1. Without a request, gnt_valid is 0 in t+1.
- R3: A successful response has gnt_ok = 1 and gnt_vc equal to the index of a VC that was free. That VC's bit in vc_free is 0 from t+1, so the port's free count drops by one per grant.
- R4: Requesters that target one port in the same cycle are served in round-robin order. The order starts at the requester after the last winner on that port (requester 0 after reset). The k-th requester served gets the k-th lowest free VC, so no two of them get the same VC.
- R5: A requester that finds no free VC left on its port gets gnt_valid = 1 and gnt_ok = 0.
- R6: The round-robin pointer of a port moves to the last requester served on it in that cycle. It is unchanged when nobody on the port is granted.
- R7: A release (rel_valid, rel_port, rel_vc) of a busy VC in cycle t makes it free from t+1. A request in cycle t cannot take it; a request in t+1 can.
- R8: A release that names a VC which is already free, or a VC index at or above the port's count, has no effect. When the same cycle also grants that free VC, the grant wins and the VC is busy afterwards.
- R9: A request naming a port number at or above the number of ports gets gnt_valid = 1 and gnt_ok = 0 and changes no free mask.
- R10: The VC count of each port comes from the VC_CNT parameter array. Mask bits at or above that count are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_IN | Request strobe per input buffer (head flit routed) |
| req_port | input | NUM_IN x PW | Output port targeted by each request |
| rel_valid | input | 1 | Release strobe for one VC |
| rel_port | input | PW | Output port of the VC being released |
| rel_vc | input | VW | Index of the VC being released |
| gnt_valid | output | NUM_IN | Response present for each requester |
| gnt_ok | output | NUM_IN | 1 = VC granted, 0 = invalid indication |
| gnt_vc | output | NUM_IN x VW | Granted VC index (valid when gnt_ok) |
| vc_free | output | NUM_OUT x MAX_VC | Current free mask of each port |

## Verification
A release and a grant can fall in the same cycle on the same port. The bench drives both together in three ways: the release names a busy VC while others are still free, the release names the very free VC that the grant takes, and the release comes in the cycle before a request. Each time it judges the answer and the following free mask against a behavioural model. Several requesters meeting on one port are provoked with all five inputs aiming at a single port. This is done twice, so the rotated start position and the exhaustion of VCs are both seen. A long random phase then mixes both kinds of event.

// File: rtl/vca_pkg.sv
package vca_pkg;

  // Position of requester idx in the service order that starts just after ptr.
  function automatic int ring_pos(input int idx, input int ptr, input int n);
    return (idx - ptr - 1 + 2 * n) % n;
  endfunction

  // Mask with the low cnt bits set, trimmed to the mask width.
  function automatic logic [63:0] low_ones(input int cnt);
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < 64; k++) if (k < cnt) m[k] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/vca_port_alloc.sv
module vca_port_alloc
  import vca_pkg::*;
#(
  parameter int NUM_IN = 5,
  parameter int MAX_VC = 4,
  parameter int NVC    = 2,
  localparam int VW = (MAX_VC > 1) ? $clog2(MAX_VC) : 1,
  localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_IN-1:0]            hit,
  input  logic                         rel_hit,
  input  logic [VW-1:0]                rel_vc,
  output logic [NUM_IN-1:0]            win,
  output logic [NUM_IN-1:0][VW-1:0]    win_vc,
  output logic [MAX_VC-1:0]            free_o
);

  localparam logic [MAX_VC-1:0] INIT_FREE = MAX_VC'(low_ones(NVC));

  logic [MAX_VC-1:0] free_q;
  logic [MAX_VC-1:0] taken;
  logic [MAX_VC-1:0] rel_set;
  logic [IW-1:0]     ptr_q;
  logic [IW-1:0]     ptr_d;
  logic              armed_q;

  int pos_w  [NUM_IN];
  int rank_w [NUM_IN];
  int frank_w[MAX_VC];

  // service position of each requester relative to the pointer
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) pos_w[i] = ring_pos(i, int'(ptr_q), NUM_IN);
  end

  // how many hitting requesters are served before each one
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      rank_w[i] = 0;
      for (int j = 0; j < NUM_IN; j++)
        if (hit[j] && (pos_w[j] < pos_w[i])) rank_w[i] = rank_w[i] + 1;
    end
  end

  // how many free VCs lie below each VC
  always_comb begin
    int acc;
    acc = 0;
    for (int v = 0; v < MAX_VC; v++) begin
      frank_w[v] = acc;
      if (free_q[v]) acc = acc + 1;
    end
  end

  // k-th served requester takes the k-th lowest free VC
  always_comb begin
    win    = '0;
    win_vc = '0;
    for (int i = 0; i < NUM_IN; i++)
      for (int v = 0; v < MAX_VC; v++)
        if (hit[i] && free_q[v] && (frank_w[v] == rank_w[i])) begin
          win[i]    = 1'b1;
          win_vc[i] = VW'(v);
        end
  end

  always_comb begin
    taken = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (win[i]) taken[win_vc[i]] = 1'b1;
  end

  // pointer follows the last requester served
  always_comb begin
    int best;
    best  = -1;
    ptr_d = ptr_q;
    for (int i = 0; i < NUM_IN; i++)
      if (win[i] && (pos_w[i] > best)) begin
        best  = pos_w[i];
        ptr_d = IW'(i);
      end
  end

  // only a busy, in-range VC can be handed back
  always_comb begin
    rel_set = '0;
    if (rel_hit && (int'(rel_vc) < NVC) && !free_q[rel_vc]) rel_set[rel_vc] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q  <= INIT_FREE;
      ptr_q   <= IW'(NUM_IN - 1);
      armed_q <= 1'b0;
    end else begin
      free_q  <= (free_q & ~taken) | rel_set;
      ptr_q   <= ptr_d;
      armed_q <= 1'b1;
    end
  end

  assign free_o = free_q;

  // R10
  beyond_count_chk: assert property (@(posedge clk) disable iff (rst)
    (free_q & ~INIT_FREE) == '0);

  // R4
  distinct_vc_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(taken) == $countones(win));

  // R5
  no_overgrant_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(win) <= $countones(free_q));

  // R3
  free_count_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ($countones(free_q) ==
      $past($countones(free_q)) - $past($countones(win)) + $past($countones(rel_set))));

endmodule

// File: rtl/vc_rr_alloc.sv
module vc_rr_alloc
  import vca_pkg::*;
#(
  parameter int NUM_IN  = 5,
  parameter int NUM_OUT = 5,
  parameter int MAX_VC  = 4,
  parameter int VC_CNT [NUM_OUT] = '{2, 2, 3, 4, 4},
  localparam int PW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int VW = (MAX_VC > 1) ? $clog2(MAX_VC) : 1
)(
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_IN-1:0]                 req_valid,
  input  logic [NUM_IN-1:0][PW-1:0]         req_port,
  input  logic                              rel_valid,
  input  logic [PW-1:0]                     rel_port,
  input  logic [VW-1:0]                     rel_vc,
  output logic [NUM_IN-1:0]                 gnt_valid,
  output logic [NUM_IN-1:0]                 gnt_ok,
  output logic [NUM_IN-1:0][VW-1:0]         gnt_vc,
  output logic [NUM_OUT-1:0][MAX_VC-1:0]    vc_free
);

  logic [NUM_OUT-1:0][NUM_IN-1:0]           hit;
  logic [NUM_OUT-1:0][NUM_IN-1:0]           win;
  logic [NUM_OUT-1:0][NUM_IN-1:0][VW-1:0]   win_vc;
  logic [NUM_IN-1:0]                        ok_d;
  logic [NUM_IN-1:0][VW-1:0]                vc_d;

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_port
    for (genvar i = 0; i < NUM_IN; i++) begin : g_hit
      assign hit[p][i] = req_valid[i] && (int'(req_port[i]) == p);
    end

    vca_port_alloc #(
      .NUM_IN (NUM_IN),
      .MAX_VC (MAX_VC),
      .NVC    (VC_CNT[p])
    ) u_port (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[p]),
      .rel_hit (rel_valid && (int'(rel_port) == p)),
      .rel_vc  (rel_vc),
      .win     (win[p]),
      .win_vc  (win_vc[p]),
      .free_o  (vc_free[p])
    );
  end

  // each requester hits at most one port, so OR-merging is safe
  always_comb begin
    ok_d = '0;
    vc_d = '0;
    for (int p = 0; p < NUM_OUT; p++)
      for (int i = 0; i < NUM_IN; i++)
        if (win[p][i]) begin
          ok_d[i] = 1'b1;
          vc_d[i] = win_vc[p][i];
        end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= '0;
      gnt_ok    <= '0;
      gnt_vc    <= '0;
    end else begin
      gnt_valid <= req_valid;
      gnt_ok    <= ok_d;
      gnt_vc    <= vc_d;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid[i] |=> gnt_valid[i]);
    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid[i] |=> !gnt_valid[i]);
    // R9
    bad_port_invalid_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid[i] && (int'(req_port[i]) >= NUM_OUT)) |=> !gnt_ok[i]);
    // R5
    ok_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_ok[i] |-> gnt_valid[i]);
  end

endmodule

// File: tb/vc_rr_alloc_tb.sv
module vc_rr_alloc_tb;
  localparam int NUM_IN  = 5;
  localparam int NUM_OUT = 5;
  localparam int MAX_VC  = 4;
  localparam int PW      = 3;
  localparam int VW      = 2;
  localparam int VC_CNT [NUM_OUT] = '{2, 2, 3, 4, 4};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                           rst;
  logic [NUM_IN-1:0]              req_valid;
  logic [NUM_IN-1:0][PW-1:0]      req_port;
  logic                           rel_valid;
  logic [PW-1:0]                  rel_port;
  logic [VW-1:0]                  rel_vc;
  logic [NUM_IN-1:0]              gnt_valid;
  logic [NUM_IN-1:0]              gnt_ok;
  logic [NUM_IN-1:0][VW-1:0]      gnt_vc;
  logic [NUM_OUT-1:0][MAX_VC-1:0] vc_free;

  vc_rr_alloc #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .MAX_VC(MAX_VC), .VC_CNT(VC_CNT)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .rel_valid(rel_valid), .rel_port(rel_port), .rel_vc(rel_vc),
    .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_vc(gnt_vc), .vc_free(vc_free)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit mfree [NUM_OUT][MAX_VC];
  int mptr  [NUM_OUT];
  bit e_valid [NUM_IN];
  bit e_ok    [NUM_IN];
  int e_vc    [NUM_IN];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = '0;
    req_port  = '0;
    rel_valid = 1'b0;
    rel_port  = '0;
    rel_vc    = '0;
  endtask

  task automatic model_cycle();
    bit old [NUM_OUT][MAX_VC];
    bit tk  [NUM_OUT][MAX_VC];
    old = mfree;
    for (int p = 0; p < NUM_OUT; p++)
      for (int v = 0; v < MAX_VC; v++) tk[p][v] = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      e_valid[i] = req_valid[i];
      e_ok[i]    = 1'b0;
      e_vc[i]    = 0;
    end
    for (int p = 0; p < NUM_OUT; p++) begin
      int last;
      last = -1;
      for (int s = 1; s <= NUM_IN; s++) begin
        int i;
        bit found;
        i = (mptr[p] + s) % NUM_IN;
        found = 1'b0;
        if (req_valid[i] && int'(req_port[i]) == p)
          for (int v = 0; v < VC_CNT[p]; v++)
            if (!found && old[p][v] && !tk[p][v]) begin
              found    = 1'b1;
              tk[p][v] = 1'b1;
              e_ok[i]  = 1'b1;
              e_vc[i]  = v;
              last     = i;
            end
      end
      if (last >= 0) mptr[p] = last;
      for (int v = 0; v < MAX_VC; v++) mfree[p][v] = old[p][v] && !tk[p][v];
    end
    if (rel_valid && int'(rel_port) < NUM_OUT)
      if (int'(rel_vc) < VC_CNT[rel_port] && !old[rel_port][rel_vc])
        mfree[rel_port][rel_vc] = 1'b1;
  endtask

  // apply current stimulus for one edge and compare at the following negedge
  task automatic step(input string tag);
    model_cycle();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_IN; i++) begin
      chk("R2", $sformatf("valid[%0d]", i), int'(gnt_valid[i]), int'(e_valid[i]));
      chk(tag, $sformatf("ok[%0d]", i), int'(gnt_ok[i]), int'(e_ok[i]));
      if (e_ok[i]) chk(tag, $sformatf("vc[%0d]", i), int'(gnt_vc[i]), e_vc[i]);
    end
    for (int p = 0; p < NUM_OUT; p++)
      for (int v = 0; v < MAX_VC; v++)
        chk(tag, $sformatf("free[%0d][%0d]", p, v), int'(vc_free[p][v]), int'(mfree[p][v]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    for (int p = 0; p < NUM_OUT; p++) begin
      mptr[p] = NUM_IN - 1;
      for (int v = 0; v < MAX_VC; v++) mfree[p][v] = (v < VC_CNT[p]);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset state
    for (int p = 0; p < NUM_OUT; p++)
      for (int v = 0; v < MAX_VC; v++)
        chk("R1", $sformatf("reset free[%0d][%0d]", p, v), int'(vc_free[p][v]), int'(v < VC_CNT[p]));
    chk("R1", "reset gnt_valid", int'(gnt_valid), 0);
    step("R10");
    chk("R1", "idle gnt_valid", int'(gnt_valid), 0);

    // R4 / R5: all requesters aim at port 3 (four VCs)
    for (int i = 0; i < NUM_IN; i++) begin req_valid[i] = 1'b1; req_port[i] = 3'd3; end
    step("R4");
    chk("R4", "req3 gets vc3", int'(gnt_vc[3]), 3);
    chk("R5", "req4 starved", int'(gnt_ok[4]), 0);
    idle();

    // R7: hand the four VCs back
    for (int v = 0; v < 4; v++) begin
      rel_valid = 1'b1; rel_port = 3'd3; rel_vc = VW'(v);
      step("R7");
    end
    idle();

    // R6: second round starts after last winner (requester 3)
    for (int i = 0; i < NUM_IN; i++) begin req_valid[i] = 1'b1; req_port[i] = 3'd3; end
    step("R6");
    chk("R6", "req4 first gets vc0", int'(gnt_vc[4]), 0);
    chk("R6", "req3 now starved", int'(gnt_ok[3]), 0);
    idle();

    // R8: release of a free VC, release beyond count
    rel_valid = 1'b1; rel_port = 3'd1; rel_vc = 2'd0;
    step("R8");
    rel_port = 3'd0; rel_vc = 2'd3;
    step("R8");
    chk("R8", "port0 vc3 stays absent", int'(vc_free[0][3]), 0);
    // R8: release and grant of the same free VC together
    rel_port = 3'd2; rel_vc = 2'd0;
    req_valid[1] = 1'b1; req_port[1] = 3'd2;
    step("R8");
    chk("R8", "grant wins vc0", int'(vc_free[2][0]), 0);
    idle();

    // R9: port numbers past the last port
    for (int i = 0; i < 3; i++) begin req_valid[i] = 1'b1; req_port[i] = PW'(5 + i); end
    step("R9");
    chk("R9", "bad port invalid", int'(gnt_ok[2:0]), 0);
    idle();

    // R7: release while busy, visible only one cycle later
    req_valid[0] = 1'b1; req_port[0] = 3'd4;
    step("R7");
    idle();
    rel_valid = 1'b1; rel_port = 3'd4; rel_vc = 2'd0;
    req_valid[1] = 1'b1; req_port[1] = 3'd4;
    step("R7");
    chk("R7", "busy vc0 not regranted", int'(gnt_vc[1]), 1);
    idle();
    req_valid[2] = 1'b1; req_port[2] = 3'd4;
    step("R7");
    chk("R7", "released vc0 reused", int'(gnt_vc[2]), 0);
    idle();

    // R3: random mix of requests and releases
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        req_valid[i] = ($urandom_range(0, 2) == 0);
        req_port[i]  = PW'($urandom_range(0, 6));
      end
      rel_valid = ($urandom_range(0, 1) == 0);
      rel_port  = PW'($urandom_range(0, 5));
      rel_vc    = VW'($urandom_range(0, 3));
      step("R3");
    end
    idle();
    step("R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule